// File: doc/BRIEF.md
# Partial-Correlation Symbol Demodulator

This block despreads a received direct-sequence symbol. It takes one signed complex sample per chip and decides which of sixteen 32-chip reference codes the symbol was spread with. It does not correlate all 32 chips coherently. Each code's symbol is cut into eight 4-chip groups. Each group is correlated on its own, and the squared magnitudes of the eight group results are added. A slow carrier phase rotation across the symbol therefore costs almost nothing. Each chip reference component is +1 or −1, so every chip product is a sign change or a swap of real and imaginary parts. The only real multiplications are the two squares per group.

Samples enter with a valid flag. A start strobe marks the first chip of a symbol and realigns the internal chip position. After the 32nd chip of a symbol has been accepted, the block outputs the winning code index and its metric together with a one-cycle valid pulse. The sixteen codes come from one base code: eight of them are cyclic rotations of it, and the other eight are complex conjugates of those rotations.

Top module: `pcorr_demod`

## Requirements
- R1: A noiseless symbol built from code n decodes as out_sym = n, for every n in 0..15.
- R2: The metric of code n is the sum over the eight groups p = 0..7 of |Σ_{k=0..3} s(4p+k)·conj(c_n(4p+k))|². Here s(m) = in_i + j·in_q of chip m, and out_metric reports the winner's metric exactly.
- R3: Each chip reference is a complex value with ±1 components. For n in 0..7, chip m of code n equals base chip (m − 4n) mod 32, and code n+8 is the conjugate of code n (its Q component is negated). Base chip m has I = −1 when bit m of BASE_I is 1 and +1 when it is 0, and Q is taken from BASE_Q in the same way. The defaults are BASE_I = 0x6B1E94D3 and BASE_Q = 0x31220276.
- R4: When several codes share the largest metric, the lowest code index wins.
- R5: With 3-bit samples, including the extreme value −4, the metric never wraps. Every metric up to 16384 is reported exactly.
- R6: out_valid is high for exactly one cycle. It rises in the cycle that follows the first clock edge after the edge that accepts chip 31. No other cycle has out_valid high.
- R7: If sym_start is high together with in_valid, that sample is chip 0 of a new symbol, and any partly received symbol is discarded.
- R8: A cycle with in_valid low does not advance the chip position or the accumulation, whatever values in_i, in_q and sym_start carry.
- R9: After reset, out_valid, out_sym and out_metric are 0 and the next accepted sample is chip 0.
- R10: out_sym and out_metric hold their values in every cycle in which out_valid is low.
- R11: Symbols may follow each other with no idle cycle, and each is decided on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample qualifier |
| sym_start | input | 1 | Marks the current sample as chip 0 |
| in_i | input | 3 | In-phase sample, signed |
| in_q | input | 3 | Quadrature sample, signed |
| out_valid | output | 1 | One-cycle decision strobe |
| out_sym | output | 4 | Decided code index |
| out_metric | output | 15 | Metric of the decided code |

## Verification
The bench builds the block with its defaults: 3-bit samples, 4-chip groups, eight groups and eight rotations, and the base code pair given in R3. With 3-bit samples the bench can apply the asymmetric extreme −4 and can reach the full metric range with a handful of directed symbols. With eight rotations plus their conjugates, it covers the complete 16-way decision and every rotation offset of the code generator. Random data with random idle gaps and realignment strobes then exercises framing against a bench model of the metric formula.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
   // bits needed for a sum of npart squared group magnitudes
   function automatic int metric_width(input int sw, input int plen, input int npart);
      return 2 * sw + 2 * $clog2(plen) + 2 + $clog2(npart);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pcd_codes.sv
module pcd_codes #(
   parameter int CHIPS = 32,
   parameter int NROT  = 8,
   parameter int CW    = 5,
   parameter logic [CHIPS-1:0] BASE_I = '0,
   parameter logic [CHIPS-1:0] BASE_Q = '0
) (
   input  logic [CW-1:0]     cur,
   output logic [2*NROT-1:0] c_i,
   output logic [2*NROT-1:0] c_q
);
   localparam int STEP = CHIPS / NROT;

   for (genvar r = 0; r < NROT; r++) begin : g_rot
      localparam int SH = r * STEP;
      logic [CW-1:0] idx;
      assign idx = (cur >= CW'(SH)) ? cur - CW'(SH) : cur + CW'(CHIPS - SH);
      // plain rotation
      assign c_i[r] = BASE_I[idx];
      assign c_q[r] = BASE_Q[idx];
      // conjugate of the same rotation
      assign c_i[r+NROT] = BASE_I[idx];
      assign c_q[r+NROT] = ~BASE_Q[idx];
   end
endmodule

// File: rtl/pcd_lane.sv
module pcd_lane #(
   parameter int SW = 3,
   parameter int PW = 7,
   parameter int MW = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_en,
   input  logic                 first_chip,
   input  logic                 last_of_part,
   input  logic                 first_part,
   input  logic signed [SW-1:0] s_i,
   input  logic signed [SW-1:0] s_q,
   input  logic                 c_i,
   input  logic                 c_q,
   output logic [MW-1:0]        metric
);
   logic signed [PW-1:0]   si_x, sq_x, t_re, t_im, p_re, p_im, n_re, n_im;
   logic signed [2*PW-1:0] re2, im2;
   logic [MW-1:0]          grp_pow;

   assign si_x = {{(PW-SW){s_i[SW-1]}}, s_i};
   assign sq_x = {{(PW-SW){s_q[SW-1]}}, s_q};

   // s * conj(c): sign changes only
   assign t_re = (c_i ? -si_x : si_x) + (c_q ? -sq_x : sq_x);
   assign t_im = (c_i ? -sq_x : sq_x) - (c_q ? -si_x : si_x);

   assign n_re = (first_chip ? '0 : p_re) + t_re;
   assign n_im = (first_chip ? '0 : p_im) + t_im;

   assign re2     = n_re * n_re;
   assign im2     = n_im * n_im;
   assign grp_pow = MW'($unsigned(re2)) + MW'($unsigned(im2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_re   <= '0;
         p_im   <= '0;
         metric <= '0;
      end else if (acc_en) begin
         p_re <= n_re;
         p_im <= n_im;
         if (last_of_part)
            metric <= (first_part ? '0 : metric) + grp_pow;
      end
   end
endmodule

// File: rtl/pcd_argmax.sv
module pcd_argmax #(
   parameter int NCODE = 16,
   parameter int MW    = 15,
   parameter int IW    = 4
) (
   input  logic [NCODE-1:0][MW-1:0] metrics,
   output logic [IW-1:0]            best_idx,
   output logic [MW-1:0]            best_metric
);
   // heap layout: node k has children 2k (lower codes) and 2k+1
   logic [MW-1:0] hm [1:2*NCODE-1];
   logic [IW-1:0] hi [1:2*NCODE-1];

   always_comb begin
      for (int n = 0; n < NCODE; n++) begin
         hm[NCODE+n] = metrics[n];
         hi[NCODE+n] = IW'(n);
      end
      for (int k = NCODE - 1; k >= 1; k--) begin
         if (hm[2*k] >= hm[2*k+1]) begin
            hm[k] = hm[2*k];
            hi[k] = hi[2*k];
         end else begin
            hm[k] = hm[2*k+1];
            hi[k] = hi[2*k+1];
         end
      end
   end

   assign best_idx    = hi[1];
   assign best_metric = hm[1];
endmodule

// File: rtl/pcorr_demod.sv
module pcorr_demod #(
   parameter int SW    = 3,
   parameter int PLEN  = 4,
   parameter int NPART = 8,
   parameter int NROT  = 8,
   parameter logic [NPART*PLEN-1:0] BASE_I = 32'h6B1E_94D3,
   parameter logic [NPART*PLEN-1:0] BASE_Q = 32'h3122_0276
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 sym_start,
   input  logic signed [SW-1:0] in_i,
   input  logic signed [SW-1:0] in_q,
   output logic                 out_valid,
   output logic [$clog2(2*NROT)-1:0] out_sym,
   output logic [pcd_pkg::metric_width(SW, PLEN, NPART)-1:0] out_metric
);
   localparam int CHIPS = NPART * PLEN;
   localparam int NCODE = 2 * NROT;
   localparam int CW    = $clog2(CHIPS);
   localparam int IW    = $clog2(NCODE);
   localparam int LGP   = $clog2(PLEN);
   localparam int PW    = SW + 2 + LGP;
   localparam int MW    = pcd_pkg::metric_width(SW, PLEN, NPART);
   localparam logic [MW-1:0] MAX_METRIC = MW'(NPART) << (2*SW + 2*LGP + 1);

   if (SW < 2) begin : g_bad_sw
      $error("pcorr_demod: SW must be at least 2");
   end
   if (!pcd_pkg::is_pow2(PLEN) || PLEN < 2) begin : g_bad_plen
      $error("pcorr_demod: PLEN must be a power of two, at least 2");
   end
   if (!pcd_pkg::is_pow2(NROT)) begin : g_bad_nrot
      $error("pcorr_demod: NROT must be a power of two");
   end
   if (CHIPS % NROT != 0) begin : g_bad_step
      $error("pcorr_demod: chips per symbol must divide by NROT");
   end

   logic [CW-1:0]            chip_idx, cur;
   logic                     acc, is_last, dec_q;
   logic                     first_chip, last_of_part, first_part;
   logic [NCODE-1:0]         code_i, code_q;
   logic [NCODE-1:0][MW-1:0] lane_m;
   logic [IW-1:0]            best_i;
   logic [MW-1:0]            best_m;

   assign acc          = in_valid;
   assign cur          = sym_start ? '0 : chip_idx;
   assign is_last      = (cur == CW'(CHIPS - 1));
   assign first_chip   = (cur[LGP-1:0] == '0);
   assign last_of_part = (cur[LGP-1:0] == LGP'(PLEN - 1));
   assign first_part   = (cur[CW-1:LGP] == '0);

   pcd_codes #(.CHIPS(CHIPS), .NROT(NROT), .CW(CW), .BASE_I(BASE_I), .BASE_Q(BASE_Q))
      u_codes (.cur(cur), .c_i(code_i), .c_q(code_q));

   for (genvar n = 0; n < NCODE; n++) begin : g_lane
      pcd_lane #(.SW(SW), .PW(PW), .MW(MW)) u_lane (
         .clk(clk), .rst_n(rst_n), .acc_en(acc),
         .first_chip(first_chip), .last_of_part(last_of_part), .first_part(first_part),
         .s_i(in_i), .s_q(in_q), .c_i(code_i[n]), .c_q(code_q[n]),
         .metric(lane_m[n]));
   end

   pcd_argmax #(.NCODE(NCODE), .MW(MW), .IW(IW))
      u_argmax (.metrics(lane_m), .best_idx(best_i), .best_metric(best_m));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chip_idx   <= '0;
         dec_q      <= 1'b0;
         out_valid  <= 1'b0;
         out_sym    <= '0;
         out_metric <= '0;
      end else begin
         dec_q     <= acc && is_last;
         out_valid <= dec_q;
         if (acc)
            chip_idx <= is_last ? '0 : cur + CW'(1);
         if (dec_q) begin
            out_sym    <= best_i;
            out_metric <= best_m;
         end
      end
   end
endmodule

// File: rtl/pcd_chk.sv
module pcd_chk #(
   parameter int CHIPS = 32,
   parameter int CW    = 5,
   parameter int IW    = 4,
   parameter int MW    = 15,
   parameter logic [MW-1:0] MAXM = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          sym_start,
   input logic [CW-1:0] chip_idx,
   input logic          out_valid,
   input logic [IW-1:0] out_sym,
   input logic [MW-1:0] out_metric
);
   logic last_acc;
   assign last_acc = in_valid && !sym_start && (chip_idx == CW'(CHIPS - 1));

   // R6
   pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R6
   decide_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_acc |=> ##1 out_valid);
   // R6
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(dec_src));
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(chip_idx));
   // R7
   realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sym_start) |=> (chip_idx == CW'(1)));
   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_sym) && $stable(out_metric)));
   // R5
   metric_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_metric <= MAXM));

   // last chip accepted, delayed by one edge (symbol start on a 1-chip symbol is excluded by parameters)
   logic dec_src;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dec_src <= 1'b0;
      else        dec_src <= last_acc || (in_valid && sym_start && CHIPS == 1);
   end
endmodule

bind pcorr_demod pcd_chk #(.CHIPS(CHIPS), .CW(CW), .IW(IW), .MW(MW), .MAXM(MAX_METRIC)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_start(sym_start),
   .chip_idx(chip_idx), .out_valid(out_valid), .out_sym(out_sym), .out_metric(out_metric));

// File: tb/tb_pcorr_demod.sv
module tb_pcorr_demod;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 3, PLEN = 4, NPART = 8, NROT = 8;
   localparam int CHIPS = NPART * PLEN;
   localparam logic [31:0] BI = 32'h6B1E_94D3;
   localparam logic [31:0] BQ = 32'h3122_0276;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sym_start = 1'b0;
   logic signed [2:0] in_i = '0, in_q = '0;
   logic        out_valid;
   logic [3:0]  out_sym;
   logic [14:0] out_metric;

   pcorr_demod #(.SW(SW), .PLEN(PLEN), .NPART(NPART), .NROT(NROT), .BASE_I(BI), .BASE_Q(BQ)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_start(sym_start),
      .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_sym(out_sym), .out_metric(out_metric));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   int q_sym[$], q_met[$], q_cyc[$];
   int last_sym = 0, last_met = 0;
   bit finished = 0;
   logic signed [2:0] vi [CHIPS];
   logic signed [2:0] vq [CHIPS];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // R3 reference chip of code n at position m
   function automatic void ref_chip(input int n, input int m, output int ci, output int cq);
      int idx;
      idx = (m - (n % NROT) * (CHIPS / NROT) + CHIPS) % CHIPS;
      ci = BI[idx] ? -1 : 1;
      cq = BQ[idx] ? -1 : 1;
      if (n >= NROT) cq = -cq;
   endfunction

   // R2/R4 metric model with lowest-index tie break
   function automatic void model(output int best, output int bm);
      best = 0; bm = -1;
      for (int n = 0; n < 2*NROT; n++) begin
         int tot = 0;
         for (int p = 0; p < NPART; p++) begin
            int re = 0, im = 0;
            for (int k = 0; k < PLEN; k++) begin
               int ci, cq, si, sq;
               ref_chip(n, p*PLEN + k, ci, cq);
               si = vi[p*PLEN + k]; sq = vq[p*PLEN + k];
               re += si*ci + sq*cq;
               im += sq*ci - si*cq;
            end
            tot += re*re + im*im;
         end
         if (tot > bm) begin bm = tot; best = n; end
      end
   endfunction

   function automatic void fill_code(input int n, input int pos, input int neg);
      for (int m = 0; m < CHIPS; m++) begin
         int ci, cq;
         ref_chip(n, m, ci, cq);
         vi[m] = 3'(ci > 0 ? pos : neg);
         vq[m] = 3'(cq > 0 ? pos : neg);
      end
   endfunction

   task automatic idle_cycle();
      @(negedge clk);
      in_valid = 1'b0;
      in_i = 3'($urandom); in_q = 3'($urandom);
      sym_start = 1'($urandom);  // R8: ignored while in_valid is low
   endtask

   task automatic send_sym(input bit st, input int gapmax, input int exp_sym);
      int b, bm;
      model(b, bm);
      if (exp_sym >= 0) b = exp_sym;
      for (int m = 0; m < CHIPS; m++) begin
         int g = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
         repeat (g) idle_cycle();
         @(negedge clk);
         in_valid = 1'b1; in_i = vi[m]; in_q = vq[m];
         sym_start = st && (m == 0);
         if (m == CHIPS - 1) begin
            q_sym.push_back(b); q_met.push_back(bm); q_cyc.push_back(cyc + 2);
         end
      end
   endtask

   // decision monitor: R1 R2 R6 R10
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid) begin
            if (q_sym.size() == 0) check("R6", "unexpected out_valid", 1, 0);
            else begin
               check("R1", "out_sym", out_sym, q_sym.pop_front());
               check("R2", "out_metric", out_metric, q_met.pop_front());
               check("R6", "decision cycle", cyc, q_cyc.pop_front());
            end
            last_sym = out_sym; last_met = out_metric;
         end else begin
            check("R10", "held out_sym", out_sym, last_sym);
            check("R10", "held out_metric", out_metric, last_met);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R6 watchdog: cycles %0d expected below %0d", cyc, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      // R9 outputs under and after reset
      @(negedge clk);
      check("R9", "out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "out_valid", out_valid, 0);
      check("R9", "out_sym", out_sym, 0);
      check("R9", "out_metric", out_metric, 0);

      // R1 R3 clean codes, amplitude 3, back-to-back (R11)
      for (int n = 0; n < 2*NROT; n++) begin
         fill_code(n, 3, -3);
         send_sym(n == 0, 0, n);
      end
      // R4 all-zero: every metric 0, code 0 wins
      for (int m = 0; m < CHIPS; m++) begin vi[m] = '0; vq[m] = '0; end
      send_sym(0, 1, 0);
      // R4 single unit chip: every metric equals 2, code 0 wins
      vi[0] = 3'sd1;
      send_sym(0, 0, 0);
      // R5 extreme samples (-4 on negative chips)
      fill_code(5, 3, -4);
      send_sym(0, 2, -1);
      fill_code(12, 3, -4);
      send_sym(0, 0, -1);
      for (int m = 0; m < CHIPS; m++) begin vi[m] = -3'sd4; vq[m] = -3'sd4; end
      send_sym(0, 0, -1);
      // R7 partial symbol discarded on realignment
      for (int j = 0; j < 10; j++) begin
         @(negedge clk);
         in_valid = 1'b1; sym_start = 1'b0;
         in_i = 3'($urandom); in_q = 3'($urandom);
      end
      fill_code(9, 3, -3);
      send_sym(1, 0, 9);
      // R8 R11 random data with gaps and strobes
      for (int s = 0; s < 40; s++) begin
         for (int m = 0; m < CHIPS; m++) begin
            vi[m] = 3'($urandom); vq[m] = 3'($urandom);
         end
         send_sym(1'($urandom), (s % 2) * 3, -1);
      end
      // noisy code symbols
      for (int s = 0; s < 8; s++) begin
         fill_code(int'($urandom % 16), 2, -2);
         for (int m = 0; m < CHIPS; m++) begin
            vi[m] = vi[m] + 3'(int'($urandom % 3) - 1);
            vq[m] = vq[m] + 3'(int'($urandom % 3) - 1);
         end
         send_sym(0, 1, -1);
      end
      @(negedge clk);
      in_valid = 1'b0; sym_start = 1'b0;
      repeat (6) @(negedge clk);
      check("R6", "pending decisions", q_sym.size(), 0);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule